// File: doc/BRIEF.md
# Parallel SAD Block-Matching Motion Estimator

This block finds the motion of one image point between two consecutive 8-bit grayscale frames. It compares a small reference patch from the older frame against every placement inside a larger search area from the newer frame. The score for each placement is the sum of absolute differences (SAD). The placement with the lowest score is reported as a signed displacement pair (dx, dy). The camera is assumed to move by no more than two pixels per frame, so a 4x4 reference patch is matched inside an 8x8 search area. That gives 5x5 candidate displacements, each running from -2 to +2.

A window is delivered as four valid beats, one reference row per beat. With each reference row come the five search rows that line up with it, one for each vertical offset. Five window units, one per vertical offset, each hold twenty absolute-difference elements: four reference columns times five horizontal offsets. One fetched reference row therefore feeds all horizontally adjacent placements in the same cycle, and every one of the 25 running sums advances on every beat. A strict-minimum scan then selects the winner. The displacement comes out one clock edge after the last row is taken in. The next window may start on the beat right after the last one.

Top module: `sad_motion_engine`

## Requirements
- R1: Pixels are unsigned 8-bit values, and each element takes the magnitude of their difference in both directions: a reference of 255 against a search pixel of 0 scores the same as 0 against 255.
- R2: The score of candidate (dx, dy) is the sum over r, c in 0..3 of |ref[r][c] - search[r+dy+2][c+dx+2]|. On beat r, `srch_rows` carries search rows r..r+4: search row r+v sits in bits [v*64 +: 64], and its column j in bits [j*8 +: 8] of that slice. Reference column c sits in `ref_row` bits [c*8 +: 8].
- R3: Running sums are 12 bits wide. The largest possible score, 16*255 = 4080, neither wraps nor loses its order against other scores.
- R4: A window is the next four beats with `in_valid` high. Cycles with `in_valid` low, whatever their data, change neither the scores nor the result.
- R5: `mv_valid` is high for exactly one cycle per window. It rises on the clock edge that follows the edge sampling the window's fourth valid beat.
- R6: The lowest score wins. On equal scores, the candidate that comes first in raster order wins: dy ascending, then dx ascending.
- R7: `mv_dx` and `mv_dy` are 3-bit two's complement values in -2..+2. Positive dx means the match lies to the right, and positive dy means the match lies lower.
- R8: Each window's sums start fresh on its first beat. A window that follows right after another, with no idle cycle, gives the same result it would give on its own.
- R9: While reset is low, `mv_valid`, `mv_dx` and `mv_dy` are 0, and the next valid beat is taken as the first row of a window.
- R10: Between pulses, `mv_dx` and `mv_dy` keep the last reported displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Current beat carries a window row |
| ref_row | input | 32 | One reference row, 4 pixels |
| srch_rows | input | 320 | Five aligned search rows, 8 pixels each |
| mv_valid | output | 1 | One-cycle result strobe |
| mv_dx | output | 3 | Horizontal displacement, signed |
| mv_dy | output | 3 | Vertical displacement, signed |

## Verification
The assertions take it for granted that every window is made of exactly four valid beats and that reset is released before any beat is sent. The single-pulse and timing properties rely on a gap of at least four beats between windows, which a complete window always provides. The stimulus only ever sends whole windows, with or without idle cycles between their rows. It plants the reference patch at all 25 displacements, builds all-equal and near-saturated frames to force ties and the largest sums, and fills idle cycles with random data.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int DEF_PIX_W = 8;   // gray level width
    localparam int DEF_REF_N = 4;   // reference patch edge
    localparam int DEF_RANGE = 2;   // max displacement per axis

    function automatic int pos_count(input int range);
        return 2 * range + 1;
    endfunction
endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] absdiff
);
    always_comb begin
        if (pix_a >= pix_b) absdiff = pix_a - pix_b;
        else                absdiff = pix_b - pix_a;
    end
endmodule

// File: rtl/sad_window_unit.sv
module sad_window_unit #(
    parameter int PIX_W  = 8,
    parameter int REF_N  = 4,
    parameter int NPOS   = 5,
    parameter int ACC_W  = 12,
    localparam int SRCH_N = REF_N + NPOS - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat,
    input  logic                      first_row,
    input  logic [REF_N*PIX_W-1:0]    ref_row,
    input  logic [SRCH_N*PIX_W-1:0]   srch_row,
    output logic [NPOS*ACC_W-1:0]     sums
);
    typedef struct packed {
        logic [NPOS-1:0][ACC_W-1:0] acc;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic [PIX_W-1:0] diff [NPOS][REF_N];
    logic [ACC_W-1:0] part [NPOS];

    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        for (genvar c = 0; c < REF_N; c++) begin : g_col
            sad_pe #(.PIX_W(PIX_W)) u_pe (
                .pix_a  (ref_row[c*PIX_W +: PIX_W]),
                .pix_b  (srch_row[(p+c)*PIX_W +: PIX_W]),
                .absdiff(diff[p][c])
            );
        end
    end

    always_comb begin
        for (int p = 0; p < NPOS; p++) begin
            part[p] = '0;
            for (int c = 0; c < REF_N; c++) begin
                part[p] = part[p] + ACC_W'(diff[p][c]);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (beat) begin
            for (int p = 0; p < NPOS; p++) begin
                if (first_row) st_d.acc[p] = part[p];
                else           st_d.acc[p] = st_q.acc[p] + part[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sums = st_q.acc;
endmodule

// File: rtl/sad_argmin.sv
module sad_argmin #(
    parameter int NPOS  = 5,
    parameter int ACC_W = 12,
    localparam int IDX_W = $clog2(NPOS)
) (
    input  logic [NPOS*NPOS*ACC_W-1:0] sums,
    output logic [IDX_W-1:0]           best_row,
    output logic [IDX_W-1:0]           best_col
);
    logic [ACC_W-1:0] best;

    always_comb begin
        best     = sums[0 +: ACC_W];
        best_row = '0;
        best_col = '0;
        for (int v = 0; v < NPOS; v++) begin
            for (int p = 0; p < NPOS; p++) begin
                if (sums[(v*NPOS+p)*ACC_W +: ACC_W] < best) begin
                    best     = sums[(v*NPOS+p)*ACC_W +: ACC_W];
                    best_row = IDX_W'(v);
                    best_col = IDX_W'(p);
                end
            end
        end
    end
endmodule

// File: rtl/sad_motion_engine.sv
module sad_motion_engine #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W,
    parameter int REF_N = sad_pkg::DEF_REF_N,
    parameter int RANGE = sad_pkg::DEF_RANGE,
    localparam int NPOS   = sad_pkg::pos_count(RANGE),
    localparam int SRCH_N = REF_N + 2 * RANGE,
    localparam int ACC_W  = PIX_W + $clog2(REF_N * REF_N),
    localparam int MV_W   = $clog2(RANGE + 1) + 1,
    localparam int ROW_W  = (REF_N > 1) ? $clog2(REF_N) : 1,
    localparam int IDX_W  = $clog2(NPOS),
    localparam int ROWB   = SRCH_N * PIX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [REF_N*PIX_W-1:0]     ref_row,
    input  logic [NPOS*ROWB-1:0]       srch_rows,
    output logic                       mv_valid,
    output logic [MV_W-1:0]            mv_dx,
    output logic [MV_W-1:0]            mv_dy
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             done;
        logic             vld;
        logic [MV_W-1:0]  dx;
        logic [MV_W-1:0]  dy;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [NPOS*NPOS*ACC_W-1:0] all_sums;
    logic [IDX_W-1:0] win_row, win_col;
    logic first_row, last_row;

    assign first_row = (st_q.row == '0);
    assign last_row  = (st_q.row == ROW_W'(REF_N - 1));

    for (genvar v = 0; v < NPOS; v++) begin : g_unit
        sad_window_unit #(
            .PIX_W(PIX_W), .REF_N(REF_N), .NPOS(NPOS), .ACC_W(ACC_W)
        ) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat     (in_valid),
            .first_row(first_row),
            .ref_row  (ref_row),
            .srch_row (srch_rows[v*ROWB +: ROWB]),
            .sums     (all_sums[v*NPOS*ACC_W +: NPOS*ACC_W])
        );
    end

    sad_argmin #(.NPOS(NPOS), .ACC_W(ACC_W)) u_min (
        .sums    (all_sums),
        .best_row(win_row),
        .best_col(win_col)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid && last_row;
        st_d.vld  = st_q.done;
        if (in_valid) begin
            st_d.row = last_row ? '0 : st_q.row + ROW_W'(1);
        end
        if (st_q.done) begin
            st_d.dx = MV_W'(int'(win_col) - RANGE);
            st_d.dy = MV_W'(int'(win_row) - RANGE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mv_valid = st_q.vld;
    assign mv_dx    = st_q.dx;
    assign mv_dy    = st_q.dy;
endmodule

// File: rtl/sad_motion_engine_chk.sv
module sad_motion_engine_chk #(
    parameter int MV_W  = 3,
    parameter int RANGE = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            mv_valid,
    input logic [MV_W-1:0] mv_dx,
    input logic [MV_W-1:0] mv_dy
);
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |=> !mv_valid);

    assert_follows_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> $past(in_valid, 2));

    assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> ($signed(mv_dx) >= -RANGE && $signed(mv_dx) <= RANGE &&
                      $signed(mv_dy) >= -RANGE && $signed(mv_dy) <= RANGE));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_valid |-> ($stable(mv_dx) && $stable(mv_dy)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mv_valid && mv_dx == '0 && mv_dy == '0));
endmodule

bind sad_motion_engine sad_motion_engine_chk #(.MV_W(MV_W), .RANGE(RANGE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .mv_valid(mv_valid),
    .mv_dx   (mv_dx),
    .mv_dy   (mv_dy)
);

// File: tb/sad_motion_engine_tb.sv
`timescale 1ns/1ps
module sad_motion_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  ref_row = '0;
    logic [319:0] srch_rows = '0;
    logic         mv_valid;
    logic [2:0]   mv_dx, mv_dy;

    int n_vec = 0, n_bad = 0, cyc = 0, seed = 7;
    int refw [4][4];
    int srch [8][8];
    int exp_dx [512], exp_dy [512], exp_cyc [512];
    int exp_n = 0, rd = 0;
    logic prev_vld = 1'b0;

    sad_motion_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ref_row(ref_row),
        .srch_rows(srch_rows), .mv_valid(mv_valid), .mv_dx(mv_dx), .mv_dy(mv_dy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // independent model: SAD per candidate, strict minimum in raster order
    task automatic model(output int ex, output int ey);
        int best = 1 << 30;
        ex = 0; ey = 0;
        for (int dy = 0; dy < 5; dy++)
            for (int dx = 0; dx < 5; dx++) begin
                int s = 0;
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++) begin
                        int d = refw[r][c] - srch[r+dy][c+dx];
                        s += (d < 0) ? -d : d;
                    end
                if (s < best) begin best = s; ex = dx - 2; ey = dy - 2; end
            end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            for (int k = 0; k < 10; k++) srch_rows[k*32 +: 32] = {rnd()[7:0], rnd()[7:0], rnd()[7:0], rnd()[7:0]};
            ref_row = {rnd()[7:0], rnd()[7:0], rnd()[7:0], rnd()[7:0]};
        end
    endtask

    task automatic send_window(input int gap);
        int ex, ey;
        model(ex, ey);
        for (int r = 0; r < 4; r++) begin
            if (r > 0 && gap > 0) idle(gap);
            @(negedge clk);
            in_valid = 1'b1;
            for (int c = 0; c < 4; c++) ref_row[c*8 +: 8] = 8'(refw[r][c]);
            for (int v = 0; v < 5; v++)
                for (int j = 0; j < 8; j++)
                    srch_rows[(v*8 + j)*8 +: 8] = 8'(srch[r+v][j]);
            if (r == 3) begin
                exp_dx[exp_n] = ex; exp_dy[exp_n] = ey; exp_cyc[exp_n] = cyc + 2;
                exp_n++;
            end
        end
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) srch[i][j] = rnd();
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) refw[i][j] = rnd();
    endtask

    // result monitor: R5 timing/pulse, R2/R6/R7 values
    always @(negedge clk) begin
        if (rst_n) begin
            if (mv_valid && prev_vld) check("R5 pulse width", 2, 1);
            if (mv_valid) begin
                if (rd < exp_n) begin
                    check("R5 result cycle", cyc, exp_cyc[rd]);
                    check("R2/R6/R7 dx", int'($signed(mv_dx)), exp_dx[rd]);
                    check("R2/R6/R7 dy", int'($signed(mv_dy)), exp_dy[rd]);
                end else check("R5 unexpected pulse", rd, exp_n);
                rd++;
            end
        end
        prev_vld = mv_valid;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 valid in reset", int'(mv_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", int'(mv_valid), 0);
        check("R9 dx after reset", int'(mv_dx), 0);
        check("R9 dy after reset", int'(mv_dy), 0);

        // R2 R7 R8: reference planted at each displacement, windows back to back
        for (int dy = -2; dy <= 2; dy++)
            for (int dx = -2; dx <= 2; dx++) begin
                fill_rand();
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++) refw[r][c] = srch[r+dy+2][c+dx+2];
                send_window(0);
            end
        idle(4);
        // R10: hold between pulses
        check("R10 dx hold", int'($signed(mv_dx)), exp_dx[exp_n-1]);
        check("R10 dy hold", int'($signed(mv_dy)), exp_dy[exp_n-1]);
        check("R5 no pulse while idle", int'(mv_valid), 0);

        // R6: all scores equal, first candidate wins -> (-2,-2)
        for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) srch[i][j] = 100;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) refw[i][j] = 100;
        send_window(0);
        idle(3);
        check("R6 tie dx", int'($signed(mv_dx)), -2);
        check("R6 tie dy", int'($signed(mv_dy)), -2);

        // R3: near-saturated sums, lowest at (+2,+2) = 16*254
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) srch[i][j] = (i >= 4 && j >= 4) ? 254 : 255;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) refw[i][j] = 0;
        send_window(0);
        idle(3);
        check("R3 wide sum dx", int'($signed(mv_dx)), 2);
        check("R3 wide sum dy", int'($signed(mv_dy)), 2);

        // R1: reference above search, minimum at (-2,+2)
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) srch[i][j] = (i >= 4 && j < 4) ? 1 : 0;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) refw[i][j] = 255;
        send_window(0);
        idle(3);
        check("R1 reversed sign dx", int'($signed(mv_dx)), -2);
        check("R1 reversed sign dy", int'($signed(mv_dy)), 2);

        // R4: idle cycles with garbage between rows
        for (int k = 0; k < 20; k++) begin
            fill_rand();
            send_window(1 + (k % 3));
            idle(k % 2);
        end
        idle(4);

        // random windows, back to back
        for (int k = 0; k < 40; k++) begin
            fill_rand();
            send_window(0);
        end
        idle(5);
        check("R5 one pulse per window", rd, exp_n);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule